// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block turns the pins of a small general-purpose input port into interrupt sources. Each pin first passes through a two-stage synchroniser. It then goes to a trigger stage that works in one of seven modes. In a level mode the pin sets its pending bit on every clock while the level holds. In an edge mode a pending bit is set once, when the chosen transition occurs. There is also a mode that forces the bit set and a mode that disables the pin.

Software works through a plain register bus. It selects each pin's mode and sets an enable mask. It can read the raw pending bits, the pending bits filtered by the mask, and the synchronised pin levels. Writing ones to the acknowledge word clears pending bits. A single registered interrupt line is high whenever any enabled pending bit is set.

The bus carries control and status only, so it has no stream handshake. A cycle with `bus_sel` high is an access. A write takes effect at that clock edge. A read returns its data on `bus_rdata` from the following cycle onward.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads as zero and `irq` is low.
- R2: The configuration word at address 0 holds three bits per pin, with pin i in bits 3i+2..3i. The mode codes are 0 off, 1 level high, 2 level low, 3 always set, 4 rising, 5 falling and 6 any edge. A written value reads back unchanged.
- R3: In level-high and level-low modes, the pending bit is set on every cycle the synchronised level matches. An acknowledge clears the bit only once the level has gone.
- R4: In mode 3, the pending bit is set on every cycle, whatever the pin does.
- R5: In modes 4, 5 and 6, the matching transition of the synchronised pin sets the pending bit. The bit then holds until it is acknowledged.
- R6: A write to address 4 clears each pending bit whose data bit is 1. Bits written as 0 are left unchanged.
- R7: Modes 0 and 7 never set a pending bit.
- R8: The mask register is at address 1. Address 3 reads the raw pending bits ANDed with the mask. Changing the mask does not alter the configuration word or the raw pending bits, which read at address 2.
- R9: `irq` is a register. It is high one cycle after any pending bit that is also enabled in the mask.
- R10: Address 5 reads the synchronised pin levels in every mode.
- R11: Read data is registered and valid the cycle after the read. Writes to the read-only addresses 2, 3 and 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NPINS | Asynchronous port pins |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check four things:
- `irq` tracks the masked pending bits one cycle late.
- Masked-status reads return the raw pending bits ANDed with the mask.
- A pin in mode 3 is always pending.
- A disabled pin never becomes pending, and an acknowledge clears it.

The bench scenarios cover the rest. They show that each edge and level mode responds to real pin activity through the synchroniser, and that a level pending bit comes back after an acknowledge. They also show that the configuration survives mask changes and that writes to read-only addresses are ignored.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    TRIG_OFF  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_SET  = 3'd3,
    TRIG_RISE = 3'd4,
    TRIG_FALL = 3'd5,
    TRIG_ANY  = 3'd6,
    TRIG_RSVD = 3'd7
  } trig_mode_e;

  typedef enum logic [2:0] {
    REG_CFG  = 3'd0,
    REG_MASK = 3'd1,
    REG_RAW  = 3'd2,
    REG_MSKD = 3'd3,
    REG_ACK  = 3'd4,
    REG_DIN  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [STAGES-1:0][W-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              lvl,
  input  logic              ack,
  output logic              pend
);
  logic prev_q;
  logic hit;

  always_comb begin
    case (trig_mode_e'(mode))
      TRIG_HIGH: hit = lvl;
      TRIG_LOW:  hit = ~lvl;
      TRIG_SET:  hit = 1'b1;
      TRIG_RISE: hit = lvl & ~prev_q;
      TRIG_FALL: hit = ~lvl & prev_q;
      TRIG_ANY:  hit = lvl ^ prev_q;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= lvl;
      pend   <= hit | (pend & ~ack);
    end
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  parameter int unsigned AW    = 3,
  parameter int unsigned DW    = 32,
  localparam int unsigned CFG_W = NPINS * MODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] raw_pend,
  input  logic [NPINS-1:0] din,
  output logic [CFG_W-1:0] cfg_q,
  output logic [NPINS-1:0] mask_q,
  output logic [NPINS-1:0] ack_pulse
);
  logic          wr_en, rd_en;
  logic [DW-1:0] rd_mux;

  assign wr_en = bus_sel & bus_we;
  assign rd_en = bus_sel & ~bus_we;

  assign ack_pulse = (wr_en && bus_addr == AW'(REG_ACK)) ? bus_wdata[NPINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (bus_addr == AW'(REG_CFG))  cfg_q  <= bus_wdata[CFG_W-1:0];
      if (bus_addr == AW'(REG_MASK)) mask_q <= bus_wdata[NPINS-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(REG_CFG):  rd_mux = DW'(cfg_q);
      AW'(REG_MASK): rd_mux = DW'(mask_q);
      AW'(REG_RAW):  rd_mux = DW'(raw_pend);
      AW'(REG_MSKD): rd_mux = DW'(raw_pend & mask_q);
      AW'(REG_DIN):  rd_mux = DW'(din);
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  parameter int unsigned AW    = 3,
  parameter int unsigned DW    = 32,
  parameter int unsigned SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq
);
  localparam int unsigned CFG_W = NPINS * MODE_W;

  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] raw_pend;
  logic [NPINS-1:0] mask_q;
  logic [NPINS-1:0] ack_pulse;
  logic [CFG_W-1:0] cfg_q;

  gpio_irq_sync #(.W(NPINS), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pin_sync)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_irq_trig u_trig (
      .clk  (clk),
      .rst_n(rst_n),
      .mode (cfg_q[i*MODE_W +: MODE_W]),
      .lvl  (pin_sync[i]),
      .ack  (ack_pulse[i]),
      .pend (raw_pend[i])
    );
  end

  gpio_irq_regs #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .raw_pend(raw_pend), .din(pin_sync),
    .cfg_q(cfg_q), .mask_q(mask_q), .ack_pulse(ack_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(raw_pend & mask_q);
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  parameter int unsigned AW    = 3,
  parameter int unsigned DW    = 32,
  localparam int unsigned CFG_W = NPINS * MODE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_q,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] raw_pend,
  input logic             irq,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata
);
  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    |(raw_pend & mask_q) |=> irq);
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(raw_pend & mask_q)) |=> !irq);

  assert_masked_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == AW'(REG_MSKD))
    |=> bus_rdata == DW'($past(raw_pend & mask_q)));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin_chk
    logic [MODE_W-1:0] m;
    logic              is_off;
    assign m      = cfg_q[i*MODE_W +: MODE_W];
    assign is_off = (m == MODE_W'(TRIG_OFF)) || (m == MODE_W'(TRIG_RSVD));

    assert_set_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (m == MODE_W'(TRIG_SET)) |=> raw_pend[i]);

    assert_off_no_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_off && !raw_pend[i]) |=> !raw_pend[i]);

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (is_off && bus_sel && bus_we && bus_addr == AW'(REG_ACK) && bus_wdata[i])
      |=> !raw_pend[i]);
  end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .mask_q(mask_q), .raw_pend(raw_pend),
  .irq(irq), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 8;
  localparam int AW = 3;
  localparam int DW = 32;
  localparam int WATCHDOG = 20000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPINS-1:0] pin_in = '0;
  logic             bus_sel = 1'b0;
  logic             bus_we = 1'b0;
  logic [AW-1:0]    bus_addr = '0;
  logic [DW-1:0]    bus_wdata = '0;
  logic [DW-1:0]    bus_rdata;
  logic             irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } exp_item_t;
  exp_item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NPINS), .AW(AW), .DW(DW)) i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic report(input bit ok, input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: one expected item per read, compared once the read data is registered (R11).
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && bus_sel && !bus_we) begin
        #1;
        if (exp_q.size() == 0) begin
          report(1'b0, "R11 unexpected read", bus_rdata, '0);
        end else begin
          exp_item_t it;
          it = exp_q.pop_front();
          report(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    exp_item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic set_pins(input logic [NPINS-1:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_irq(input logic e, input string tag);
    repeat (3) @(negedge clk);
    report(irq === e, tag, DW'(irq), DW'(e));
  endtask

  localparam logic [DW-1:0] CFG_VAL =
      (DW'(1) << 0) | (DW'(2) << 3) | (DW'(3) << 6) | (DW'(4) << 9) |
      (DW'(5) << 12) | (DW'(6) << 15) | (DW'(0) << 18) | (DW'(7) << 21);

  initial begin
    fork
      begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
          n_checks++; n_fails++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    report(irq === 1'b0, "R1 irq after reset", DW'(irq), 0);
    bus_read(3'd0, 0, "R1 cfg reset");
    bus_read(3'd1, 0, "R1 mask reset");
    bus_read(3'd2, 0, "R1 raw reset");
    bus_read(3'd3, 0, "R1 masked reset");
    bus_read(3'd5, 0, "R1 din reset");

    // Pin modes: 0 high, 1 low, 2 set, 3 rise, 4 fall, 5 any, 6 off, 7 code 7
    bus_write(3'd0, CFG_VAL);
    bus_read(3'd0, CFG_VAL, "R2 cfg readback");
    repeat (3) @(negedge clk);
    bus_read(3'd2, 32'h06, "R3 R4 low and set pending with pins low");
    bus_read(3'd3, 32'h00, "R8 masked with mask zero");
    check_irq(1'b0, "R9 irq low with mask zero");

    bus_write(3'd1, 32'hFF);
    bus_read(3'd3, 32'h06, "R8 masked with full mask");
    check_irq(1'b1, "R9 irq high with enabled pending");

    bus_write(3'd4, 32'h06);
    bus_read(3'd2, 32'h06, "R3 level low and set re-assert after ack");

    set_pins(8'h01);
    bus_read(3'd2, 32'h07, "R3 level high pending");

    set_pins(8'h09);
    bus_read(3'd2, 32'h0F, "R5 rising edge pending");
    bus_write(3'd4, 32'h08);
    bus_read(3'd2, 32'h07, "R6 ack clears edge pending");
    bus_write(3'd4, 32'h00);
    bus_read(3'd2, 32'h07, "R6 zero ack has no effect");

    set_pins(8'h19);
    bus_read(3'd2, 32'h07, "R5 falling mode ignores rise");
    set_pins(8'h09);
    bus_read(3'd2, 32'h17, "R5 falling edge pending");

    set_pins(8'h29);
    bus_read(3'd2, 32'h37, "R5 any edge on rise");
    bus_write(3'd4, 32'h20);
    bus_read(3'd2, 32'h17, "R6 ack any edge");
    set_pins(8'h09);
    bus_read(3'd2, 32'h37, "R5 any edge on fall");

    set_pins(8'hC9);
    bus_read(3'd2, 32'h37, "R7 off and code 7 pins ignore toggles");
    bus_read(3'd5, 32'hC9, "R10 din shows synchronised pins");

    bus_write(3'd1, 32'h00);
    bus_read(3'd3, 32'h00, "R8 masked after mask clear");
    bus_read(3'd0, CFG_VAL, "R8 cfg unchanged by mask");
    bus_read(3'd2, 32'h37, "R8 raw unchanged by mask");
    check_irq(1'b0, "R9 irq low after mask clear");

    bus_write(3'd2, 32'hFF);
    bus_write(3'd3, 32'hFF);
    bus_write(3'd5, 32'h00);
    bus_read(3'd2, 32'h37, "R11 read-only writes ignored raw");
    bus_read(3'd5, 32'hC9, "R11 read-only writes ignored din");
    bus_read(3'd1, 32'h00, "R11 mask untouched by read-only writes");

    bus_write(3'd1, 32'h10);
    bus_read(3'd3, 32'h10, "R8 single-bit mask");
    check_irq(1'b1, "R9 irq from one enabled pin");
    bus_write(3'd4, 32'h10);
    check_irq(1'b0, "R9 irq drops after ack");
    bus_read(3'd2, 32'h27, "R6 ack clears only written bit");

    set_pins(8'hC8);
    bus_read(3'd2, 32'h27, "R3 high pending held after level goes");
    bus_write(3'd4, 32'h01);
    bus_read(3'd2, 32'h26, "R3 ack clears level once gone");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) report(1'b0, "R11 reads left unchecked", DW'(exp_q.size()), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule